// File: doc/BRIEF.md
# Processor-Side Interrupt Recognition Unit

This unit sits beside the instruction sequencer of a processor core. It looks at an encoded interrupt request level from the system's interrupt controller and compares it with the interrupt mask held in the status register. The comparison happens only when the sequencer pulses an instruction-boundary strobe. When the unit accepts a request, it switches the core into supervisor mode, turns trace off, and runs a byte-wide interrupt-acknowledge fetch on the bus. That fetch carries a dedicated transfer-type and modifier code, so the memory system does not treat it as an ordinary read. The unit captures the 8-bit vector the bus returns and presents it to the exception logic.

Levels 1 to 6 act on their level. Each one is taken only when it is strictly greater than the mask. Level 7 is non-maskable and acts on its edge. The unit latches a change of the request level from below 7 to 7 as a pending event, and that event stays pending until its acknowledge completes. While the unit is not in an acknowledge, the sequencer can rewrite the status register through a load port. When an acknowledge completes, the unit raises the mask to the level it serviced.

Top module: `irq_recog`

## Requirements
- R1: After a synchronous active-low reset, `ack_req` and `vec_valid` are 0 and `sr_out` is 16'h2700. In that value, supervisor (bit 13) is 1, trace (bit 15) is 0 and the mask (bits 10:8) is 7.
- R2: The unit takes an interrupt only at a clock edge where `insn_boundary` is 1. A qualifying level with no strobe never raises `ack_req`.
- R3: A request level L from 1 to 6 is taken only if L is strictly greater than the mask in `sr_out[10:8]`. A level equal to or below the mask is not taken.
- R4: Level 7 is taken whatever the mask is, including mask 7. It is taken on a change of the level from any value below 7 to 7, and not on the level alone. A level held at 7 after its service is not taken again. The level seen before the first edge after reset counts as 0.
- R5: A level-7 edge stays pending until a boundary takes it, even if the request level has dropped by then. The pending event is cleared when the level-7 acknowledge completes.
- R6: When a level-7 event is pending, it is taken ahead of any level from 1 to 6 present at the same boundary.
- R7: `ack_req` rises in the cycle after the boundary edge that accepts a request. From that cycle on, `sr_out[13]` is 1 and `sr_out[15]` is 0.
- R8: While `ack_req` is 1, these outputs hold until the cycle in which `bus_ready` is 1: `ack_level` equals the accepted level, `ack_tt` is 2'b11 and `ack_tm` equals the accepted level. Boundary strobes during this time have no effect.
- R9: The value on `bus_data` in the cycle where `ack_req` and `bus_ready` are both 1 appears on `vec_out` in the next cycle. In that cycle `vec_valid` is 1 for exactly one cycle and `ack_req` is 0. `vec_out` then holds that value until the next capture.
- R10: In the cycle after an acknowledge completes, `sr_out[10:8]` equals the serviced level, so later requests at that level or below are not taken.
- R11: A pulse on `sr_load` writes `sr_load_val` into `sr_out` at the next edge. Where the unit updates a bit at that same edge (on a take or a completion), the unit's value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_level | input | 3 | Encoded interrupt request level, 0 = none |
| insn_boundary | input | 1 | One-cycle strobe at each instruction boundary |
| sr_load | input | 1 | Write strobe for the status register |
| sr_load_val | input | 16 | Status register value to write |
| bus_ready | input | 1 | Bus completes the acknowledge fetch this cycle |
| bus_data | input | 8 | Vector byte returned by the acknowledge fetch |
| sr_out | output | 16 | Status register (15 trace, 13 supervisor, 10:8 mask) |
| ack_req | output | 1 | Acknowledge fetch in progress |
| ack_level | output | 3 | Level being acknowledged |
| ack_tt | output | 2 | Transfer type, 2'b11 during acknowledge, else 0 |
| ack_tm | output | 3 | Transfer modifier, the acknowledged level, else 0 |
| vec_out | output | 8 | Last captured vector |
| vec_valid | output | 1 | One-cycle pulse when a new vector is on `vec_out` |

## Verification
Random status-register loads, level changes and strobes are run against a bench model that tracks the mask and a level-7 pending flag of its own. The random mix separates a strict comparison from a greater-or-equal one, and level-triggered from edge-triggered treatment of level 7. Directed cases cover several situations:
- level equal to the mask;
- a qualifying level with no strobe;
- a level-7 edge under mask 7, held and then dropped;
- a pending level 7 competing with level 5;
- a strobe during a stalled acknowledge;
- a status-register load that collides with a completion.

Random bus stall lengths check that the acknowledge outputs hold steady and that the vector pulse comes exactly one cycle after the ready cycle.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Shared constants for the interrupt recognition unit: status register
// layout, the acknowledge transfer code and the sequencer state type.
package irq_pkg;
    localparam int SR_W      = 16;
    localparam int SR_TRACE  = 15;
    localparam int SR_SUPER  = 13;
    localparam int SR_MASK_L = 8;
    localparam int LVL_W     = 3;
    localparam int SR_MASK_H = SR_MASK_L + LVL_W - 1;
    localparam logic [SR_W-1:0] SR_RESET = 16'h2700;
    localparam logic [1:0] TT_IACK = 2'b11;

    typedef enum logic {SEQ_IDLE, SEQ_ACK} seq_state_t;
endpackage

// File: rtl/irq_l7_edge.sv
// Module irq_l7_edge
// Detects a change of the request level from below the top level to the
// top level and keeps it pending until the top-level acknowledge completes.
// Assumes req_level changes synchronously to clk. The level before the
// first edge after reset is taken as 0.
module irq_l7_edge #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] req_level,
    input  logic             clr,
    output logic             nmi_active
);
    localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

    logic [LVL_W-1:0] prev_lvl;
    logic             pend;
    logic             rise;

    // Purpose: a new arrival at the top level this cycle.
    assign rise = (req_level == TOP) && (prev_lvl != TOP);
    // Purpose: pending event, including one that arrives in this cycle.
    assign nmi_active = pend | rise;

    // Purpose: remember the last level and hold the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl <= '0;
            pend     <= 1'b0;
        end else begin
            prev_lvl <= req_level;
            if (rise)
                pend <= 1'b1;
            else if (clr)
                pend <= 1'b0;
        end
    end

    // R5: the pending flag drops only through a completed top-level acknowledge
    a_r5_pend_cleared_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> $past(clr));
endmodule

// File: rtl/irq_decide.sv
// Module irq_decide
// Combinational acceptance test at an instruction boundary. A pending
// top-level event wins. Other non-zero levels must be strictly above the
// mask. A level held at the top level is never accepted by its level alone.
module irq_decide #(
    parameter int LVL_W = 3
) (
    input  logic             boundary,
    input  logic             idle,
    input  logic             nmi_active,
    input  logic [LVL_W-1:0] req_level,
    input  logic [LVL_W-1:0] mask,
    output logic             take,
    output logic [LVL_W-1:0] take_lvl
);
    localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

    logic level_ok;

    // Purpose: levels below the top act on their level against the mask.
    assign level_ok = (req_level != TOP) && (req_level > mask);

    // Purpose: accept at a boundary while idle and pick the level to serve.
    always_comb begin
        take     = boundary && idle && (nmi_active || level_ok);
        take_lvl = nmi_active ? TOP : req_level;
    end
endmodule

// File: rtl/irq_ack_seq.sv
// Module irq_ack_seq
// Runs the byte-wide acknowledge fetch. It raises the request after an
// accept and holds it until bus_ready, then captures the vector and
// pulses vec_valid for one cycle. Assumes bus_data is valid whenever
// bus_ready is high during an acknowledge.
module irq_ack_seq
    import irq_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [LVL_W-1:0] take_lvl,
    input  logic             bus_ready,
    input  logic [VEC_W-1:0] bus_data,
    output logic             idle,
    output logic             done,
    output logic             ack_req,
    output logic [LVL_W-1:0] ack_level,
    output logic [1:0]       ack_tt,
    output logic [LVL_W-1:0] ack_tm,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid
);
    seq_state_t       state;
    logic [LVL_W-1:0] lvl_q;

    // Purpose: decode the bus-facing attributes from the sequencer state.
    always_comb begin
        idle      = (state == SEQ_IDLE);
        ack_req   = (state == SEQ_ACK);
        done      = ack_req && bus_ready;
        ack_level = lvl_q;
        ack_tt    = ack_req ? TT_IACK : 2'b00;
        ack_tm    = ack_req ? lvl_q : '0;
    end

    // Purpose: step the sequencer, hold the level and capture the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            lvl_q     <= '0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= 1'b0;
            case (state)
                SEQ_IDLE: if (take) begin
                    state <= SEQ_ACK;
                    lvl_q <= take_lvl;
                end
                SEQ_ACK: if (bus_ready) begin
                    state     <= SEQ_IDLE;
                    vec_out   <= bus_data;
                    vec_valid <= 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R8: a stalled acknowledge keeps its request and level
    a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req && !bus_ready |=> ack_req && $stable(ack_level));
    // R9: the vector strobe lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);
    // R9: a capture follows a ready cycle of an acknowledge
    a_r9_capture_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> $past(ack_req && bus_ready));
endmodule

// File: rtl/irq_sr_reg.sv
// Module irq_sr_reg
// Holds the status register. Software loads are applied first. Supervisor
// entry, trace clear and the mask raise at acknowledge completion then
// override the affected bits at the same edge.
module irq_sr_reg
    import irq_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SR_W-1:0]  load_val,
    input  logic             enter,
    input  logic             done,
    input  logic [LVL_W-1:0] done_lvl,
    output logic [SR_W-1:0]  sr
);
    // Purpose: status register with unit updates taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= SR_RESET;
        end else begin
            if (load)
                sr <= load_val;
            if (enter) begin
                sr[SR_SUPER] <= 1'b1;
                sr[SR_TRACE] <= 1'b0;
            end
            if (done)
                sr[SR_MASK_H:SR_MASK_L] <= done_lvl;
        end
    end
endmodule

// File: rtl/irq_recog.sv
// Module irq_recog
// Top of the interrupt recognition unit. It links the level-7 edge
// detector, the boundary decision, the acknowledge sequencer and the
// status register. Assumes insn_boundary is a one-cycle strobe from the
// instruction sequencer.
module irq_recog
    import irq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] req_level,
    input  logic             insn_boundary,
    input  logic             sr_load,
    input  logic [SR_W-1:0]  sr_load_val,
    input  logic             bus_ready,
    input  logic [VEC_W-1:0] bus_data,
    output logic [SR_W-1:0]  sr_out,
    output logic             ack_req,
    output logic [LVL_W-1:0] ack_level,
    output logic [1:0]       ack_tt,
    output logic [LVL_W-1:0] ack_tm,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid
);
    localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

    logic             nmi_active;
    logic             idle;
    logic             take;
    logic             done;
    logic             nmi_clr;
    logic [LVL_W-1:0] take_lvl;

    // Purpose: clear the level-7 event once its own acknowledge finishes.
    assign nmi_clr = done && (ack_level == TOP);

    irq_l7_edge #(.LVL_W(LVL_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .req_level(req_level),
        .clr(nmi_clr), .nmi_active(nmi_active)
    );

    irq_decide #(.LVL_W(LVL_W)) u_decide (
        .boundary(insn_boundary), .idle(idle), .nmi_active(nmi_active),
        .req_level(req_level), .mask(sr_out[SR_MASK_H:SR_MASK_L]),
        .take(take), .take_lvl(take_lvl)
    );

    irq_ack_seq #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .take(take), .take_lvl(take_lvl),
        .bus_ready(bus_ready), .bus_data(bus_data), .idle(idle), .done(done),
        .ack_req(ack_req), .ack_level(ack_level), .ack_tt(ack_tt),
        .ack_tm(ack_tm), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    irq_sr_reg #(.LVL_W(LVL_W)) u_sr (
        .clk(clk), .rst_n(rst_n), .load(sr_load), .load_val(sr_load_val),
        .enter(take), .done(done), .done_lvl(ack_level), .sr(sr_out)
    );

    // R2: an acknowledge starts only after a boundary strobe
    a_r2_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req) |-> $past(insn_boundary));
    // R3: a non-top level is accepted only above the mask that was in force
    a_r3_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req) && (ack_level != TOP) |-> ack_level > $past(sr_out[SR_MASK_H:SR_MASK_L]));
    // R7: supervisor set and trace clear while the acknowledge begins
    a_r7_mode_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req) |-> sr_out[SR_SUPER] && !sr_out[SR_TRACE]);
    // R8: the acknowledge is tagged with its transfer code
    a_r8_tagged_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> (ack_tt == TT_IACK) && (ack_tm == ack_level));
    // R10: the mask equals the serviced level when the vector appears
    a_r10_mask_raised: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> sr_out[SR_MASK_H:SR_MASK_L] == $past(ack_level));
endmodule

// File: tb/irq_recog_test.sv
`timescale 1ns/1ps
module irq_recog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  req_level = '0;
    logic        insn_boundary = 1'b0;
    logic        sr_load = 1'b0;
    logic [15:0] sr_load_val = '0;
    logic        bus_ready = 1'b0;
    logic [7:0]  bus_data = '0;
    logic [15:0] sr_out;
    logic        ack_req;
    logic [2:0]  ack_level;
    logic [1:0]  ack_tt;
    logic [2:0]  ack_tm;
    logic [7:0]  vec_out;
    logic        vec_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] m_sr;
    logic [2:0]  m_prev;
    bit          m_pend;
    logic [7:0]  m_vec;

    always #4 clk = ~clk;

    irq_recog uut (
        .clk(clk), .rst_n(rst_n), .req_level(req_level),
        .insn_boundary(insn_boundary), .sr_load(sr_load),
        .sr_load_val(sr_load_val), .bus_ready(bus_ready), .bus_data(bus_data),
        .sr_out(sr_out), .ack_req(ack_req), .ack_level(ack_level),
        .ack_tt(ack_tt), .ack_tm(ack_tm), .vec_out(vec_out),
        .vec_valid(vec_valid)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Level the model expects to be taken at a boundary now, 0 = none.
    function automatic logic [2:0] exp_take();
        if (m_pend) return 3'd7;
        if (m_prev != 3'd7 && m_prev > m_sr[10:8]) return m_prev;
        return 3'd0;
    endfunction

    // Called just after a negedge: changes the level with no clock advance.
    task automatic set_level(logic [2:0] l);
        if (l == 3'd7 && m_prev != 3'd7) m_pend = 1;
        m_prev = l;
        req_level = l;
    endtask

    task automatic load_sr(logic [15:0] v);
        sr_load = 1'b1;
        sr_load_val = v;
        @(negedge clk);
        sr_load = 1'b0;
        m_sr = v;
        check("R11 load", sr_out, m_sr);
    endtask

    task automatic idle_cycles(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R2 no strobe no take", {15'd0, ack_req}, 16'd0);
        end
    endtask

    // Runs the acknowledge to completion, with an optional colliding load.
    task automatic service(logic [2:0] lvl, int stall, bit do_load, logic [15:0] lv);
        for (int i = 0; i < stall; i++) begin
            insn_boundary = (i == 0);
            @(negedge clk);
            insn_boundary = 1'b0;
            check("R8 held req", {15'd0, ack_req}, 16'd1);
            check("R8 held level", {13'd0, ack_level}, {13'd0, lvl});
            check("R8 tt", {14'd0, ack_tt}, 16'd3);
        end
        m_vec = 8'($urandom);
        bus_ready = 1'b1;
        bus_data = m_vec;
        sr_load = do_load;
        sr_load_val = lv;
        @(negedge clk);
        bus_ready = 1'b0;
        bus_data = 8'($urandom);
        sr_load = 1'b0;
        if (do_load) m_sr = lv;
        m_sr[10:8] = lvl;
        if (lvl == 3'd7) m_pend = 0;
        check("R9 valid", {15'd0, vec_valid}, 16'd1);
        check("R9 vector", {8'd0, vec_out}, {8'd0, m_vec});
        check("R9 req dropped", {15'd0, ack_req}, 16'd0);
        check("R10 mask raised / R11 precedence", sr_out, m_sr);
        @(negedge clk);
        check("R9 single pulse", {15'd0, vec_valid}, 16'd0);
        check("R9 vector held", {8'd0, vec_out}, {8'd0, m_vec});
    endtask

    task automatic boundary(int stall);
        logic [2:0] e;
        e = exp_take();
        insn_boundary = 1'b1;
        @(negedge clk);
        insn_boundary = 1'b0;
        check("R3 R4 R6 take decision", {15'd0, ack_req}, {15'd0, e != 3'd0});
        if (e != 3'd0) begin
            m_sr[13] = 1'b1;
            m_sr[15] = 1'b0;
            check("R7 mode on entry", sr_out, m_sr);
            check("R8 level", {13'd0, ack_level}, {13'd0, e});
            check("R8 modifier", {13'd0, ack_tm}, {13'd0, e});
            check("R8 type", {14'd0, ack_tt}, 16'd3);
            service(e, stall, 1'b0, 16'd0);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        m_sr = 16'h2700; m_prev = 3'd0; m_pend = 0; m_vec = 8'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sr", sr_out, 16'h2700);
        check("R1 ack_req", {15'd0, ack_req}, 16'd0);
        check("R1 vec_valid", {15'd0, vec_valid}, 16'd0);

        // R3: level equal to the mask is refused, one above is accepted.
        load_sr(16'h2300);
        set_level(3'd3); boundary(0);
        set_level(3'd4); idle_cycles(3);    // R2
        boundary(2);
        // R10: same level is now blocked.
        boundary(0);
        // R4: level 7 under mask 7, taken from its edge after it drops (R5).
        load_sr(16'h2700);
        set_level(3'd6); boundary(0);
        set_level(3'd7); @(negedge clk);
        set_level(3'd2); @(negedge clk);
        boundary(1);
        // R4: held at 7 after service is not taken again.
        set_level(3'd7); boundary(0);
        boundary(0);
        // R6: a pending 7 beats a 5 above the mask.
        load_sr(16'h0000);
        set_level(3'd1); @(negedge clk);
        set_level(3'd7); @(negedge clk);
        set_level(3'd5);
        boundary(3);
        // R11: a load colliding with a completion keeps the unit's mask.
        load_sr(16'h8000);
        set_level(3'd3);
        insn_boundary = 1'b1;
        @(negedge clk);
        insn_boundary = 1'b0;
        m_sr[13] = 1'b1; m_sr[15] = 1'b0;
        check("R7 mode on entry", sr_out, m_sr);
        service(3'd3, 1, 1'b1, 16'hA5F1);

        // Random mix.
        for (int it = 0; it < 400; it++) begin
            case ($urandom % 4)
                0: load_sr(16'($urandom) & 16'hFFFF);
                1: begin set_level(3'($urandom)); @(negedge clk); end
                2: boundary($urandom % 4);
                default: begin
                    @(negedge clk);
                    check("R2 no strobe no take", {15'd0, ack_req}, 16'd0);
                end
            endcase
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule